// File: doc/BRIEF.md
# Lock-Guarded Board Control Register Bank

This block is a bank of memory-mapped status and control registers for a board controller. It sits on a simple single-cycle bus with a 12-bit byte offset and 32-bit data. It holds an LED word, a lock word, volatile and retained flag words with separate set and clear offsets, a reset-level register, a display-control register and a card-status word that follows two input pins. A strapped identification word is also readable. Bits 27:16 of that word form a board-variant code, and this code decides how the reset-level and display registers behave.

Reset-level writes are accepted only while the lock word holds the unlock key 0xA05F. An accepted write whose trigger bit is set produces a one-cycle reset request. The position of the trigger bit depends on the variant. Read data is registered. Any access to an offset outside the map raises a one-cycle error strobe.

Top module: `sysctl_bank`

## Requirements
- R1: A write to 0x20 whose data equals 0x0000A05F stores 0xA05F in the lock word. Any other write stores only data bits 14:0, so bit 15 reads as 0. A read of 0x20 returns the lock word.
- R2: A write to 0x30 ORs the data into the flag word, and a write to 0x34 clears the flag bits that are 1 in the data. A read of 0x30 returns the flag word, and a read of 0x34 returns 0. The retained flags behave the same way at 0x38 (set and read) and 0x3C (clear, reads 0).
- R3: A write to 0x40 is stored only when the lock word equals 0xA05F and the variant is 0x100, 0x178 or 0x182. On those variants a read of 0x40 returns the stored value. On every other variant it reads 0 and writes have no effect.
- R4: rst_req_o is high for exactly the cycle after an accepted write to 0x40 whose data has bit 8 set (variant 0x100) or bit 2 set (variants 0x178 and 0x182). Otherwise it is low.
- R5: The display word at 0x50 resets to 0x00001F00. On variant 0x190 it reads 0 and ignores writes.
- R6: On variants 0x100 and 0x140, a write to 0x50 keeps bits 13:8 and loads all other bits from the data. On variants 0x178 and 0x182, bit 7 keeps its value and all other bits load. Other variants ignore the write.
- R7: mux_sel_o resets to 0. It loads data bits 1:0 on a write to 0x50 only on variant 0x100.
- R8: A read of 0x48 returns card_det_i in bit 0. It returns wr_prot_i in bit 2 on variants 0x100 and 0x140, and in bit 1 on other variants. All other bits are 0.
- R9: 0x00 reads the identification word. 0x04, 0x4C, 0x58 and 0x60 read 0. 0x44 reads 1. 0x88 reads 0xFF000000. Writes to these offsets have no effect.
- R10: rst_ni low clears the LED, lock, flag and reset-level words, and also rdata_o and the strobes. It leaves the retained flags unchanged.
- R11: An access to an unmapped offset changes no register, a read of it returns 0, and bad_access_o is high for exactly the following cycle.
- R12: rdata_o loads the read value on the clock edge that accepts a read and holds it otherwise. A write to 0x08 sets led_o, and 0x08 reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| id_word_i | input | 32 | Strapped identification word; bits 27:16 are the variant |
| card_det_i | input | 1 | Card present pin |
| wr_prot_i | input | 1 | Card write-protect pin |
| rdata_o | output | 32 | Registered read data |
| bad_access_o | output | 1 | Pulse after an unmapped access |
| rst_req_o | output | 1 | Reset request pulse |
| mux_sel_o | output | 2 | Display format select |
| led_o | output | 32 | LED word |

## Verification
The assertions are checked on every cycle. They cover the following invariants:
- The lock word never has bit 15 set unless it holds the key.
- A reset request only follows an unlocked write to the reset-level offset.
- The error strobe only follows an access.
- A set write leaves its bits set.
- Display bits 13:8 survive writes on the variants that protect them.
- The display offset reads zero on variant 0x190.

Only the bench scenarios can show the following behaviours:
- The exact values produced by the variant-dependent write masks.
- The trigger bit position for each variant.
- The card-status bit placement.
- Retention of the retained flags through a reset.
- The absence of side effects from unmapped accesses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] LOCK_KEY = 16'hA05F;

  localparam logic [11:0] VAR_BASE = 12'h100;
  localparam logic [11:0] VAR_LITE = 12'h140;
  localparam logic [11:0] VAR_MID  = 12'h178;
  localparam logic [11:0] VAR_MAX  = 12'h182;
  localparam logic [11:0] VAR_NEXT = 12'h190;

  localparam logic [AW-1:0] OFF_ID     = 12'h000;
  localparam logic [AW-1:0] OFF_SW     = 12'h004;
  localparam logic [AW-1:0] OFF_LED    = 12'h008;
  localparam logic [AW-1:0] OFF_LOCK   = 12'h020;
  localparam logic [AW-1:0] OFF_FSET   = 12'h030;
  localparam logic [AW-1:0] OFF_FCLR   = 12'h034;
  localparam logic [AW-1:0] OFF_NSET   = 12'h038;
  localparam logic [AW-1:0] OFF_NCLR   = 12'h03C;
  localparam logic [AW-1:0] OFF_RST    = 12'h040;
  localparam logic [AW-1:0] OFF_PCI    = 12'h044;
  localparam logic [AW-1:0] OFF_CARD   = 12'h048;
  localparam logic [AW-1:0] OFF_FLASH  = 12'h04C;
  localparam logic [AW-1:0] OFF_DISP   = 12'h050;
  localparam logic [AW-1:0] OFF_BOOT   = 12'h058;
  localparam logic [AW-1:0] OFF_MISC   = 12'h060;
  localparam logic [AW-1:0] OFF_PID1   = 12'h088;

  localparam logic [DW-1:0] DISP_RST   = 32'h0000_1F00;
  localparam logic [DW-1:0] DISP_HI_RO = 32'h0000_3F00;
  localparam logic [DW-1:0] DISP_B7_RO = 32'h0000_0080;
  localparam logic [DW-1:0] PID1_VAL   = 32'hFF00_0000;

  typedef struct packed {
    logic disp_hi_ro;  // bits 13:8 protected
    logic disp_b7_ro;  // bit 7 protected
    logic mux_en;
    logic disp_raz;
    logic trig_b8;
    logic trig_b2;
    logic wp_hi;       // write-protect on bit 2
  } var_cfg_t;

  function automatic var_cfg_t decode_variant(input logic [11:0] v);
    var_cfg_t c;
    c.disp_hi_ro = (v == VAR_BASE) || (v == VAR_LITE);
    c.disp_b7_ro = (v == VAR_MID) || (v == VAR_MAX);
    c.mux_en     = (v == VAR_BASE);
    c.disp_raz   = (v == VAR_NEXT);
    c.trig_b8    = (v == VAR_BASE);
    c.trig_b2    = (v == VAR_MID) || (v == VAR_MAX);
    c.wp_hi      = (v == VAR_BASE) || (v == VAR_LITE);
    return c;
  endfunction
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
  parameter int DW = 32,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [KEY_W-1:0] lock_o,
  output logic             unlocked_o
);
  localparam logic [DW-1:0] KEY_WORD = DW'(KEY);
  logic [KEY_W-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else if (wr_i) lock_q <= (wdata_i == KEY_WORD) ? KEY : {1'b0, wdata_i[KEY_W-2:0]};
  end

  assign lock_o     = lock_q;
  assign unlocked_o = (lock_q == KEY);
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W = 32,
  parameter bit RESET_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (set_i)      word_d = word_q | data_i;
    else if (clr_i) word_d = word_q & ~data_i;
  end

  generate
    if (RESET_EN) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else         word_q <= word_d;
      end
    end else begin : g_keep
      logic unused_rst;
      assign unused_rst = rst_ni;
      always_ff @(posedge clk_i) word_q <= word_d;
    end
  endgenerate

  assign word_o = word_q;
endmodule

// File: rtl/sysctl_disp.sv
module sysctl_disp
  import sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  var_cfg_t      cfg_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] disp_o,
  output logic [1:0]    mux_o
);
  logic [DW-1:0] disp_q;
  logic [1:0]    mux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= DISP_RST;
      mux_q  <= '0;
    end else if (wr_i) begin
      if (cfg_i.disp_hi_ro)      disp_q <= (disp_q & DISP_HI_RO) | (wdata_i & ~DISP_HI_RO);
      else if (cfg_i.disp_b7_ro) disp_q <= (disp_q & DISP_B7_RO) | (wdata_i & ~DISP_B7_RO);
      if (cfg_i.mux_en)          mux_q  <= wdata_i[1:0];
    end
  end

  assign raw_o  = disp_q;
  assign disp_o = cfg_i.disp_raz ? '0 : disp_q;
  assign mux_o  = mux_q;
endmodule

// File: rtl/sysctl_rstctl.sv
module sysctl_rstctl
  import sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          unlocked_i,
  input  var_cfg_t      cfg_i,
  output logic [DW-1:0] level_o,
  output logic          req_o
);
  logic [DW-1:0] level_q;
  logic          req_q;
  logic          live, accept;

  assign live   = cfg_i.trig_b8 | cfg_i.trig_b2;
  assign accept = wr_i & unlocked_i & live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= accept & (cfg_i.trig_b8 ? wdata_i[8] : wdata_i[2]);
      if (accept) level_q <= wdata_i;
    end
  end

  assign level_o = live ? level_q : '0;
  assign req_o   = req_q;
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] id_word_i,
  input  logic          card_det_i,
  input  logic          wr_prot_i,
  output logic [DW-1:0] rdata_o,
  output logic          bad_access_o,
  output logic          rst_req_o,
  output logic [1:0]    mux_sel_o,
  output logic [DW-1:0] led_o
);
  var_cfg_t         cfg;
  logic             wr;
  logic [KEY_W-1:0] lock_val;
  logic             unlocked;
  logic [DW-1:0]    flags_q, nv_q, level, disp_raw, disp_rd, led_q, rdata_q, rd_val, card_word;
  logic             hit, bad_q;

  assign cfg = decode_variant(id_word_i[27:16]);
  assign wr  = req_i & we_i;

  sysctl_lock #(.DW(DW), .KEY_W(KEY_W), .KEY(LOCK_KEY)) u_lock (
    .clk_i, .rst_ni, .wr_i(wr && addr_i == OFF_LOCK), .wdata_i,
    .lock_o(lock_val), .unlocked_o(unlocked)
  );

  sysctl_setclr #(.W(DW), .RESET_EN(1'b1)) u_flags (
    .clk_i, .rst_ni, .set_i(wr && addr_i == OFF_FSET), .clr_i(wr && addr_i == OFF_FCLR),
    .data_i(wdata_i), .word_o(flags_q)
  );

  sysctl_setclr #(.W(DW), .RESET_EN(1'b0)) u_nvflags (
    .clk_i, .rst_ni, .set_i(wr && addr_i == OFF_NSET), .clr_i(wr && addr_i == OFF_NCLR),
    .data_i(wdata_i), .word_o(nv_q)
  );

  sysctl_rstctl u_rstctl (
    .clk_i, .rst_ni, .wr_i(wr && addr_i == OFF_RST), .wdata_i, .unlocked_i(unlocked),
    .cfg_i(cfg), .level_o(level), .req_o(rst_req_o)
  );

  sysctl_disp u_disp (
    .clk_i, .rst_ni, .wr_i(wr && addr_i == OFF_DISP), .wdata_i, .cfg_i(cfg),
    .raw_o(disp_raw), .disp_o(disp_rd), .mux_o(mux_sel_o)
  );

  always_comb begin
    card_word = '0;
    card_word[0] = card_det_i;
    if (cfg.wp_hi) card_word[2] = wr_prot_i;
    else           card_word[1] = wr_prot_i;
  end

  always_comb begin
    hit    = 1'b1;
    rd_val = '0;
    case (addr_i)
      OFF_ID:   rd_val = id_word_i;
      OFF_LED:  rd_val = led_q;
      OFF_LOCK: rd_val = DW'(lock_val);
      OFF_FSET: rd_val = flags_q;
      OFF_NSET: rd_val = nv_q;
      OFF_RST:  rd_val = level;
      OFF_PCI:  rd_val = DW'(1);
      OFF_CARD: rd_val = card_word;
      OFF_DISP: rd_val = disp_rd;
      OFF_PID1: rd_val = PID1_VAL;
      OFF_SW, OFF_FCLR, OFF_NCLR, OFF_FLASH, OFF_BOOT, OFF_MISC: rd_val = '0;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q   <= '0;
      rdata_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= req_i & ~hit;
      if (wr && addr_i == OFF_LED) led_q <= wdata_i;
      if (req_i && !we_i)          rdata_q <= rd_val;
    end
  end

  assign rdata_o      = rdata_q;
  assign bad_access_o = bad_q;
  assign led_o        = led_q;
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
  import sysctl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    id_word_i,
  input logic [DW-1:0]    rdata_o,
  input logic             bad_access_o,
  input logic             rst_req_o,
  input logic [KEY_W-1:0] lock_val,
  input logic             unlocked,
  input logic [DW-1:0]    flags_q,
  input logic [DW-1:0]    disp_raw
);
  logic [11:0] v;
  assign v = id_word_i[27:16];

  AST_LOCK_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_val[KEY_W-1] |-> (lock_val == LOCK_KEY)); // R1
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_FSET) |=> ((flags_q & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_RST_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_RST && !unlocked) |=> !rst_req_o); // R3
  AST_RST_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(req_i && we_i && addr_i == OFF_RST && unlocked)); // R4
  AST_DISP_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_DISP && v == VAR_NEXT) |=> (rdata_o == '0)); // R5
  AST_DISP_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_DISP && (v == VAR_BASE || v == VAR_LITE))
      |=> (disp_raw[13:8] == $past(disp_raw[13:8]))); // R6
  AST_PCI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_PCI) |=> (rdata_o == DW'(1))); // R9
  AST_BAD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_access_o |-> $past(req_i)); // R11
endmodule

bind sysctl_bank sysctl_bank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .id_word_i(id_word_i), .rdata_o(rdata_o),
  .bad_access_o(bad_access_o), .rst_req_o(rst_req_o), .lock_val(lock_val),
  .unlocked(unlocked), .flags_q(flags_q), .disp_raw(disp_raw)
);

// File: tb/sysctl_bank_tb.sv
module sysctl_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, id_word = 32'h0100_0001;
  logic        card = 1'b0, wp = 1'b0;
  logic [31:0] rdata, led;
  logic        bad, rreq;
  logic [1:0]  mux;

  int n_tests = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .id_word_i(id_word), .card_det_i(card), .wr_prot_i(wp), .rdata_o(rdata),
    .bad_access_o(bad), .rst_req_o(rreq), .mux_sel_o(mux), .led_o(led)
  );

  // behavioural reference model
  logic [31:0] m_led, m_flags, m_nv, m_lvl, m_disp, e_rdata;
  logic [15:0] m_lock;
  logic [1:0]  m_mux;
  logic        e_bad, e_rreq;

  function automatic bit mapped(input int a);
    case (a)
      'h00, 'h04, 'h08, 'h20, 'h30, 'h34, 'h38, 'h3C, 'h40, 'h44,
      'h48, 'h4C, 'h50, 'h58, 'h60, 'h88: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int a, input int v);
    case (a)
      'h00: return id_word;
      'h08: return m_led;
      'h20: return {16'h0, m_lock};
      'h30: return m_flags;
      'h38: return m_nv;
      'h40: return (v == 'h100 || v == 'h178 || v == 'h182) ? m_lvl : 32'h0;
      'h44: return 32'h1;
      'h48: return {29'h0, (v == 'h100 || v == 'h140) ? wp : 1'b0,
                    (v == 'h100 || v == 'h140) ? 1'b0 : wp, card};
      'h50: return (v == 'h190) ? 32'h0 : m_disp;
      'h88: return 32'hFF00_0000;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_led = 0; m_lock = 0; m_flags = 0; m_lvl = 0; m_disp = 32'h1F00; m_mux = 0;
      e_rdata = 0; e_bad = 0; e_rreq = 0;
    end else begin
      int v, a;
      v = int'(id_word[27:16]);
      a = int'(addr);
      e_bad = req && !mapped(a);
      e_rreq = 0;
      if (req && !we) e_rdata = m_read(a, v);
      if (req && we) begin
        case (a)
          'h08: m_led = wdata;
          'h20: m_lock = (wdata == 32'h0000_A05F) ? 16'hA05F : {1'b0, wdata[14:0]};
          'h30: m_flags = m_flags | wdata;
          'h34: m_flags = m_flags & ~wdata;
          'h38: m_nv = m_nv | wdata;
          'h3C: m_nv = m_nv & ~wdata;
          'h40: if (m_lock == 16'hA05F) begin
            if (v == 'h100) begin m_lvl = wdata; e_rreq = wdata[8]; end
            else if (v == 'h178 || v == 'h182) begin m_lvl = wdata; e_rreq = wdata[2]; end
          end
          'h50: begin
            if (v == 'h100 || v == 'h140) m_disp = (m_disp & 32'h3F00) | (wdata & ~32'h3F00);
            else if (v == 'h178 || v == 'h182) m_disp = (m_disp & 32'h80) | (wdata & ~32'h80);
            if (v == 'h100) m_mux = wdata[1:0];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      check("R12 rdata", rdata, e_rdata);
      check("R11 bad_access", {31'h0, bad}, {31'h0, e_bad});
      check("R4 rst_req", {31'h0, rreq}, {31'h0, e_rreq});
      check("R7 mux", {30'h0, mux}, {30'h0, m_mux});
      check("R12 led", led, m_led);
    end
  end

  task automatic bus(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus(1'b0, a, 32'h0);
    check(tag, rdata, exp);
  endtask

  task automatic do_reset(input logic [31:0] id);
    @(negedge clk);
    rst_n = 1'b0;
    id_word = id;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset(32'h0100_0001);
    started = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 led reset", led, 32'h0);
    check("R10 rdata reset", rdata, 32'h0);
    check("R7 mux reset", {30'h0, mux}, 32'h0);
    rd(12'h050, 32'h1F00, "R5 disp reset");
    rd(12'h020, 32'h0, "R10 lock reset");
    // R2 retained and volatile flags
    bus(1, 12'h03C, 32'hFFFF_FFFF);
    bus(1, 12'h038, 32'h0000_00A5);
    rd(12'h038, 32'hA5, "R2 nv set");
    bus(1, 12'h03C, 32'h0000_0005);
    rd(12'h038, 32'hA0, "R2 nv clear");
    bus(1, 12'h030, 32'hF0);
    bus(1, 12'h030, 32'h0F);
    rd(12'h030, 32'hFF, "R2 flag set");
    bus(1, 12'h034, 32'h0F);
    rd(12'h030, 32'hF0, "R2 flag clear");
    rd(12'h034, 32'h0, "R2 clear offset reads 0");
    // R1 lock
    bus(1, 12'h020, 32'h1234_FFFF);
    rd(12'h020, 32'h7FFF, "R1 non-key write");
    // R3 locked reset control
    bus(1, 12'h040, 32'h100);
    check("R3 no req while locked", {31'h0, rreq}, 32'h0);
    rd(12'h040, 32'h0, "R3 locked write ignored");
    bus(1, 12'h020, 32'h0000_A05F);
    rd(12'h020, 32'hA05F, "R1 key stored");
    bus(1, 12'h040, 32'h104);
    check("R4 bit8 trigger", {31'h0, rreq}, 32'h1);
    @(negedge clk);
    check("R4 one cycle", {31'h0, rreq}, 32'h0);
    rd(12'h040, 32'h104, "R3 level stored");
    bus(1, 12'h040, 32'h004);
    check("R4 bit2 no trigger on 0x100", {31'h0, rreq}, 32'h0);
    // R6 R7 display on 0x100
    bus(1, 12'h050, 32'hFFFF_FFFE);
    rd(12'h050, 32'hFFFF_DFFE, "R6 hi bits kept");
    check("R7 mux loaded", {30'h0, mux}, 32'h2);
    // R8 card
    card = 1; wp = 1;
    rd(12'h048, 32'h5, "R8 wp on bit2");
    // R9 constants
    rd(12'h044, 32'h1, "R9 pci");
    rd(12'h088, 32'hFF00_0000, "R9 pid1");
    rd(12'h004, 32'h0, "R9 switch");
    rd(12'h000, 32'h0100_0001, "R9 id");
    bus(1, 12'h044, 32'h0);
    rd(12'h044, 32'h1, "R9 write ignored");
    // R11 unmapped
    bus(1, 12'h0A0, 32'hFFFF_FFFF);
    check("R11 bad on write", {31'h0, bad}, 32'h1);
    @(negedge clk);
    check("R11 bad one cycle", {31'h0, bad}, 32'h0);
    rd(12'h0A0, 32'h0, "R11 read zero");
    rd(12'h030, 32'hF0, "R11 no side effect");
    // R12 LED
    bus(1, 12'h008, 32'h5A);
    check("R12 led out", led, 32'h5A);
    rd(12'h008, 32'h5A, "R12 led read");
    // R10 mid-run reset keeps nv
    do_reset(32'h0182_0000);
    @(negedge clk);
    check("R10 led cleared", led, 32'h0);
    rd(12'h030, 32'h0, "R10 flags cleared");
    rd(12'h038, 32'hA0, "R10 nv kept");
    rd(12'h040, 32'h0, "R10 level cleared");
    // variant 0x182
    bus(1, 12'h020, 32'h0000_A05F);
    bus(1, 12'h040, 32'h004);
    check("R4 bit2 trigger on 0x182", {31'h0, rreq}, 32'h1);
    bus(1, 12'h050, 32'h0);
    bus(1, 12'h050, 32'hFF);
    rd(12'h050, 32'h7F, "R6 bit7 kept");
    check("R7 mux untouched", {30'h0, mux}, 32'h0);
    card = 0; wp = 1;
    rd(12'h048, 32'h2, "R8 wp on bit1");
    // variant 0x190
    do_reset(32'h0190_0000);
    rd(12'h050, 32'h0, "R5 raz");
    bus(1, 12'h050, 32'hFFFF);
    rd(12'h050, 32'h0, "R5 write ignored");
    // variant 0x140
    do_reset(32'h0140_0000);
    bus(1, 12'h020, 32'h0000_A05F);
    bus(1, 12'h040, 32'h104);
    check("R3 no req on 0x140", {31'h0, rreq}, 32'h0);
    rd(12'h040, 32'h0, "R3 reads zero on 0x140");
    bus(1, 12'h050, 32'h3);
    rd(12'h050, 32'h1F03, "R6 0x140 mask");
    check("R7 no mux on 0x140", {30'h0, mux}, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule